// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port (Master or Slave)

This block moves one byte at a time over a three-wire synchronous serial link. It works in both directions at once. A single shift register sends the outgoing byte and collects the incoming byte in the same transfer. Software reaches it through a small register interface with three registers:

- a control register, which selects enable, master or slave operation, bit order, clock rate and the interrupt enable;
- a status register, which holds the completion flag and the collision flag;
- a data register, which takes the transmit byte on a write and returns the last received byte on a read.

As master, the block makes its serial clock from the system clock through a power-of-two prescaler. It holds its slave-select output low for the whole byte. As slave, it follows an external clock and an external select, both passed through a synchronizer. The clock idles low. Data is sampled on the rising (leading) edge and changed on the falling (trailing) edge.

Top module: `spi_port`

## Requirements
- R1: In master mode, writing the data register (address 2) while idle starts a byte transfer. The byte leaves on `mosi_o` most significant bit first when control bit 2 is 0. The byte collected from `miso_i` in the same transfer is then read from address 2.
- R2: When control bit 2 is 1, the byte is shifted least significant bit first in both directions.
- R3: The master clock period in system clocks is set by the code {ctrl[5], ctrl[4:3]}: 000→4, 001→16, 010→64, 011→128, 100→2, 101→8, 110→32, 111→64.
- R4: `ss_n_o` is low only while a master transfer is running. `sck_o` is low whenever `ss_n_o` is high. The first bit is on `mosi_o` before the first rising edge of `sck_o`.
- R5: The end of every byte sets status bit 0. While control bit 6 is 1, `irq` follows that flag.
- R6: A data-register write during a transfer sets status bit 1. It leaves the byte in flight unchanged.
- R7: A status read that sees a flag set, followed by a data-register access, clears both status bits. A data access without that prior status read clears nothing.
- R8: In slave mode (control bit 1 = 0), while `ss_n_i` is low, the block receives a byte from `mosi_i` on the rising edges of `sck_i`. It drives the preloaded byte on `miso_o`, changing it after each falling edge.
- R9: In slave mode, `ss_n_i` high releases `miso_oe` and cancels a partial byte. The next selection then starts from bit 0.
- R10: If `ss_n_i` goes low while the block is an enabled master, control bit 1 clears and the block becomes a slave.
- R11: Control reads back as written in bits 6..0. Bit 7 and unmapped address 3 read as 0. Read data appears on `reg_rdata` one clock after `reg_re`.
- R12: After reset, all registers are 0, `ss_n_o` is high, and `sck_o`, `miso_oe` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 data) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Completion interrupt |
| sck_o | output | 1 | Serial clock driven as master |
| sck_i | input | 1 | Serial clock received as slave |
| ss_n_o | output | 1 | Slave select driven as master, active low |
| ss_n_i | input | 1 | Own select input, active low |
| mosi_o | output | 1 | Master data out |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_i | input | 1 | Master data in |
| miso_oe | output | 1 | Output enable for `miso_o` |

## Verification
The bench builds the block with DATA_W = 8 and a two-stage synchronizer. At that width the slowest division, 128, costs about a thousand cycles per byte, so every rate code can be measured on the `sck_o` edges. With the two-stage synchronizer, a slave clock whose half period is ten system clocks still leaves margin for `miso_o` to settle before the next rising edge. The mid-byte collision, the abort by deselection and the mode fault are all driven at these defaults.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef struct packed {
    logic       irq_en;  // bit 6
    logic       dbl;     // bit 5
    logic [1:0] rate;    // bits 4:3
    logic       lsb;     // bit 2
    logic       master;  // bit 1
    logic       enable;  // bit 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // log2 of half the SCK period in system clocks
  function automatic logic [2:0] half_exp(input logic dbl, input logic [1:0] rate);
    if (rate == 2'd3) return dbl ? 3'd5 : 3'd6;
    return {rate, 1'b1} - {2'b00, dbl};
  endfunction

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else     stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen #(
  parameter  int EXP_W = 3,
  localparam int CNT_W = (1 << EXP_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [EXP_W-1:0] half_exp,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = (CNT_W'(1) << half_exp) - CNT_W'(1);
  assign tick  = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter  int DATA_W = 8,
  localparam int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              lsb_first,
  input  logic              lead,
  input  logic              trail,
  input  logic              din,
  output logic              dout,
  output logic              byte_end,
  output logic [DATA_W-1:0] shift_next,
  output logic              started
);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sample_q;
  logic              started_q;
  logic              trail_ok;

  assign trail_ok   = trail && started_q;
  assign byte_end   = trail_ok && (cnt_q == CNT_W'(DATA_W - 1));
  assign shift_next = lsb_first ? {sample_q, sh_q[DATA_W-1:1]}
                                : {sh_q[DATA_W-2:0], sample_q};
  assign dout       = lsb_first ? sh_q[0] : sh_q[DATA_W-1];
  assign started    = started_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      sample_q  <= 1'b0;
      started_q <= 1'b0;
    end else begin
      if (abort) begin
        cnt_q     <= '0;
        started_q <= 1'b0;
      end else if (lead) begin
        sample_q  <= din;
        started_q <= 1'b1;
      end else if (trail_ok) begin
        sh_q  <= shift_next;
        cnt_q <= byte_end ? '0 : cnt_q + CNT_W'(1);
        if (byte_end) started_q <= 1'b0;
      end
      if (load) sh_q <= load_data;
    end
  end

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              sck_o,
  input  logic              sck_i,
  output logic              ss_n_o,
  input  logic              ss_n_i,
  output logic              mosi_o,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic              miso_i,
  output logic              miso_oe
);

  localparam int PAD_CTRL = DATA_W - CTRL_W;
  localparam int PAD_STAT = DATA_W - 2;

  ctrl_t ctrl_q;
  logic  done_q, wcol_q, armed_q;
  logic  m_busy_q, sck_q, sck_prev_q;
  logic  irq_q, miso_oe_q;
  logic [DATA_W-1:0] rx_q, rdata_q;

  logic [2:0] sync_q;
  logic       ss_sync_n, mosi_s, sck_s;

  logic data_wr, data_rd, stat_rd, ctrl_wr, data_acc;
  logic mode_fault, s_act, busy, collide, load, start, m_abort;
  logic tick, m_lead, m_trail, s_lead, s_trail;
  logic lead, trail, din, dout, byte_end, started, shift_abort;
  logic [DATA_W-1:0] shift_next;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CTRL_W];

  // pin synchronizer: select idles high
  spi_port_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({ss_n_i, mosi_i, sck_i}),
    .q  (sync_q)
  );

  assign ss_sync_n = sync_q[2];
  assign mosi_s    = sync_q[1];
  assign sck_s     = sync_q[0];

  // register access decode
  assign data_wr  = reg_we && (reg_addr == ADDR_DATA);
  assign data_rd  = reg_re && (reg_addr == ADDR_DATA);
  assign stat_rd  = reg_re && (reg_addr == ADDR_STAT);
  assign ctrl_wr  = reg_we && (reg_addr == ADDR_CTRL);
  assign data_acc = data_wr || data_rd;

  // mode and transfer control
  assign mode_fault  = ctrl_q.enable && ctrl_q.master && !ss_sync_n;
  assign s_act       = ctrl_q.enable && !ctrl_q.master && !ss_sync_n;
  assign busy        = ctrl_q.master ? m_busy_q : started;
  assign collide     = data_wr && busy;
  assign load        = data_wr && !busy;
  assign start       = load && ctrl_q.enable && ctrl_q.master && !mode_fault;
  assign m_abort     = !ctrl_q.enable || !ctrl_q.master || mode_fault;
  assign shift_abort = !ctrl_q.enable || (ctrl_q.master ? mode_fault : ss_sync_n);

  spi_port_clkgen #(.EXP_W(3)) u_clkgen (
    .clk     (clk),
    .rst     (rst),
    .restart (start || !m_busy_q),
    .half_exp(half_exp(ctrl_q.dbl, ctrl_q.rate)),
    .tick    (tick)
  );

  assign m_lead  = m_busy_q && tick && !sck_q;
  assign m_trail = m_busy_q && tick && sck_q;
  assign s_lead  = s_act && sck_s && !sck_prev_q;
  assign s_trail = s_act && !sck_s && sck_prev_q;

  assign lead  = ctrl_q.master ? m_lead  : s_lead;
  assign trail = ctrl_q.master ? m_trail : s_trail;
  assign din   = ctrl_q.master ? miso_i  : mosi_s;

  spi_port_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .abort     (shift_abort),
    .load      (load),
    .load_data (reg_wdata),
    .lsb_first (ctrl_q.lsb),
    .lead      (lead),
    .trail     (trail),
    .din       (din),
    .dout      (dout),
    .byte_end  (byte_end),
    .shift_next(shift_next),
    .started   (started)
  );

  // master sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      m_busy_q <= 1'b0;
      sck_q    <= 1'b0;
    end else if (m_abort) begin
      m_busy_q <= 1'b0;
      sck_q    <= 1'b0;
    end else if (start) begin
      m_busy_q <= 1'b1;
      sck_q    <= 1'b0;
    end else if (m_lead) begin
      sck_q <= 1'b1;
    end else if (m_trail) begin
      sck_q <= 1'b0;
      if (byte_end) m_busy_q <= 1'b0;
    end
  end

  // control register with mode-fault demotion
  always_ff @(posedge clk) begin
    if (rst)             ctrl_q <= '0;
    else if (ctrl_wr)    ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    else if (mode_fault) ctrl_q.master <= 1'b0;
  end

  // flags and receive buffer
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      wcol_q  <= 1'b0;
      armed_q <= 1'b0;
      rx_q    <= '0;
    end else begin
      if (stat_rd && (done_q || wcol_q)) armed_q <= 1'b0 | 1'b1;
      else if (data_acc)                 armed_q <= 1'b0;

      if (byte_end)                  done_q <= 1'b1;
      else if (data_acc && armed_q)  done_q <= 1'b0;

      if (collide)                   wcol_q <= 1'b1;
      else if (data_acc && armed_q)  wcol_q <= 1'b0;

      if (byte_end) rx_q <= shift_next;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      irq_q      <= 1'b0;
      miso_oe_q  <= 1'b0;
      sck_prev_q <= 1'b0;
    end else begin
      sck_prev_q <= sck_s;
      irq_q      <= done_q && ctrl_q.irq_en;
      miso_oe_q  <= s_act;
      if (reg_re) begin
        case (reg_addr)
          ADDR_CTRL: rdata_q <= {{PAD_CTRL{1'b0}}, ctrl_q};
          ADDR_STAT: rdata_q <= {{PAD_STAT{1'b0}}, wcol_q, done_q};
          ADDR_DATA: rdata_q <= rx_q;
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;
  assign sck_o     = sck_q;
  assign ss_n_o    = !m_busy_q;
  assign mosi_o    = dout;
  assign miso_o    = dout;
  assign miso_oe   = miso_oe_q;

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic       sck_o,
  input logic       ss_n_o,
  input logic       miso_oe,
  input logic       master_bit,
  input logic       enable_bit,
  input logic       ss_sync_n,
  input logic       done_flag,
  input logic       wcol_flag,
  input logic       byte_end
);

  assert_sck_low_when_deselected_R4: assert property (@(posedge clk) disable iff (rst)
    ss_n_o |-> !sck_o);

  assert_done_from_byte_end_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> $past(byte_end));

  assert_wcol_from_data_write_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(wcol_flag) |-> $past(reg_we && reg_addr == 2'd2));

  assert_miso_quiet_as_master_R9: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> !$past(master_bit));

  assert_miso_off_when_deselected_R9: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> !$past(ss_sync_n));

  assert_mode_fault_demotes_R10: assert property (@(posedge clk) disable iff (rst)
    (master_bit && enable_bit && !ss_sync_n && !(reg_we && reg_addr == 2'd0)) |=> !master_bit);

endmodule

bind spi_port spi_port_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .sck_o     (sck_o),
  .ss_n_o    (ss_n_o),
  .miso_oe   (miso_oe),
  .master_bit(ctrl_q.master),
  .enable_bit(ctrl_q.enable),
  .ss_sync_n (ss_sync_n),
  .done_flag (done_q),
  .wcol_flag (wcol_q),
  .byte_end  (byte_end)
);

// File: tb/spi_port_test.sv
module spi_port_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, sck_o, ss_n_o, mosi_o, miso_o, miso_oe, miso_i;
  logic       sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;

  // bench-side slave model for master tests
  logic [7:0] bsh = 8'd0, cap = 8'd0, slv_val = 8'd0;
  logic       bload = 1'b0, lsb_m = 1'b0, sck_d = 1'b0;

  always #10 clk = ~clk;

  spi_port uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sck_o(sck_o), .sck_i(sck_i), .ss_n_o(ss_n_o), .ss_n_i(ss_n_i),
    .mosi_o(mosi_o), .mosi_i(mosi_i), .miso_o(miso_o), .miso_i(miso_i), .miso_oe(miso_oe)
  );

  assign miso_i = lsb_m ? bsh[0] : bsh[7];

  always @(negedge clk) begin
    sck_d <= sck_o;
    if (bload) begin
      bsh <= slv_val;
      cap <= 8'd0;
    end else if (sck_o && !sck_d) begin
      cap <= {cap[6:0], mosi_o};
    end else if (!sck_o && sck_d) begin
      bsh <= lsb_m ? {1'b0, bsh[7:1]} : {bsh[6:0], 1'b0};
    end
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic load_slave_model(input logic [7:0] v, input logic lsb);
    @(posedge clk);
    slv_val = v; lsb_m = lsb; bload = 1'b1;
    @(posedge clk);
    bload = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    @(negedge clk);
    while (!ss_n_o && t < 5000) begin @(negedge clk); t++; end
    check(req, ss_n_o, 1'b1);
  endtask

  task automatic clear_flags();
    logic [7:0] d;
    reg_read(2'd1, d);
    reg_read(2'd2, d);
  endtask

  // R12
  task automatic t_reset();
    logic [7:0] d;
    check("R12 ss_n_o", ss_n_o, 1'b1);
    check("R12 sck_o", sck_o, 1'b0);
    check("R12 miso_oe", miso_oe, 1'b0);
    check("R12 irq", irq, 1'b0);
    reg_read(2'd0, d); check("R12 ctrl", d, 8'h00);
    reg_read(2'd1, d); check("R12 status", d, 8'h00);
    reg_read(2'd2, d); check("R12 data", d, 8'h00);
  endtask

  // R11
  task automatic t_regs();
    logic [7:0] d;
    reg_write(2'd0, 8'hFF);
    reg_read(2'd0, d); check("R11 ctrl readback", d, 8'h7F);
    reg_write(2'd3, 8'hAA);
    reg_read(2'd3, d); check("R11 addr3 reads zero", d, 8'h00);
    reg_write(2'd0, 8'h00);
  endtask

  // R1, R2, R4, R5
  task automatic t_master(input logic [7:0] tx, input logic [7:0] sv,
                          input logic lsb, input logic [2:0] code);
    logic [7:0] d;
    int t = 0;
    load_slave_model(sv, lsb);
    reg_write(2'd0, {2'b01, code[2], code[1:0], lsb, 2'b11});
    reg_write(2'd2, tx);
    check("R4 ss low during transfer", ss_n_o, 1'b0);
    while (!irq && t < 5000) begin @(negedge clk); t++; end
    check("R5 irq raised", irq, 1'b1);
    check("R4 ss high after byte", ss_n_o, 1'b1);
    check(lsb ? "R2 bits sent" : "R1 bits sent", cap, lsb ? rev8(tx) : tx);
    reg_read(2'd1, d); check("R5 done flag", d, 8'h01);
    reg_read(2'd2, d); check(lsb ? "R2 bits received" : "R1 bits received", d, sv);
    reg_write(2'd0, 8'h00);
  endtask

  // R3
  task automatic t_rate(input logic [2:0] code, input int div);
    int cyc = 0, r1 = -1, r2 = -1;
    logic prev = 1'b0;
    load_slave_model(8'h00, 1'b0);
    reg_write(2'd0, {2'b00, code[2], code[1:0], 3'b011});
    reg_write(2'd2, 8'h55);
    while (r2 < 0 && cyc < 2000) begin
      if (sck_o && !prev) begin
        if (r1 < 0) r1 = cyc; else r2 = cyc;
      end
      prev = sck_o;
      @(negedge clk); cyc++;
    end
    check("R3 sck period", r2 - r1, div);
    wait_idle("R3 transfer ends");
    clear_flags();
    reg_write(2'd0, 8'h00);
  endtask

  // R6 and R7
  task automatic t_collision();
    logic [7:0] d;
    load_slave_model(8'h2B, 1'b0);
    reg_write(2'd0, 8'h1B);          // /128, master, enable
    reg_write(2'd2, 8'h96);
    repeat (100) @(negedge clk);
    reg_write(2'd2, 8'hFF);
    wait_idle("R6 transfer ends");
    check("R6 byte in flight intact", cap, 8'h96);
    reg_read(2'd1, d); check("R6 collision and done", d, 8'h03);
    reg_read(2'd2, d); check("R6 received byte", d, 8'h2B);
    reg_read(2'd1, d); check("R7 both flags cleared", d, 8'h00);
    reg_write(2'd0, 8'h00);
  endtask

  task automatic t_clear_order();
    logic [7:0] d;
    load_slave_model(8'h11, 1'b0);
    reg_write(2'd0, 8'h23);          // /2 master enable
    reg_write(2'd2, 8'h0F);
    wait_idle("R7 transfer ends");
    reg_read(2'd2, d);
    reg_read(2'd1, d); check("R7 data access alone keeps flag", d, 8'h01);
    reg_read(2'd2, d);
    reg_read(2'd1, d); check("R7 status then data clears", d, 8'h00);
    reg_write(2'd0, 8'h00);
  endtask

  // R8 slave byte
  task automatic slave_byte(input logic [7:0] mb, input logic lsb, output logic [7:0] got);
    for (int i = 0; i < 8; i++) begin
      int idx = lsb ? i : 7 - i;
      mosi_i = mb[idx];
      repeat (10) @(negedge clk);
      got[idx] = miso_o;
      sck_i = 1'b1;
      repeat (10) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic t_slave(input logic [7:0] mb, input logic [7:0] sb, input logic lsb);
    logic [7:0] d, got;
    reg_write(2'd0, {5'b01000, lsb, 2'b01});
    reg_write(2'd2, sb);
    @(negedge clk); ss_n_i = 1'b0;
    slave_byte(mb, lsb, got);
    check("R8 miso driven while selected", miso_oe, 1'b1);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 slave sent byte", got, sb);
    check("R5 irq in slave", irq, 1'b1);
    reg_read(2'd1, d); check("R8 slave done", d, 8'h01);
    reg_read(2'd2, d); check("R8 slave received byte", d, mb);
    reg_write(2'd0, 8'h00);
  endtask

  // R9
  task automatic t_ss_abort();
    logic [7:0] d, got;
    reg_write(2'd0, 8'h01);
    reg_write(2'd2, 8'hF0);
    @(negedge clk); ss_n_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      mosi_i = 1'b1;
      repeat (10) @(negedge clk); sck_i = 1'b1;
      repeat (10) @(negedge clk); sck_i = 1'b0;
    end
    repeat (10) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 miso released", miso_oe, 1'b0);
    reg_read(2'd1, d); check("R9 no done on partial", d, 8'h00);
    reg_write(2'd2, 8'h81);
    @(negedge clk); ss_n_i = 1'b0;
    slave_byte(8'h3C, 1'b0, got);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 fresh byte after abort sent", got, 8'h81);
    reg_read(2'd1, d);
    reg_read(2'd2, d); check("R9 fresh byte after abort received", d, 8'h3C);
    reg_write(2'd0, 8'h00);
  endtask

  // R10
  task automatic t_mode_fault();
    logic [7:0] d;
    reg_write(2'd0, 8'h03);
    @(negedge clk); ss_n_i = 1'b0;
    repeat (6) @(negedge clk);
    reg_read(2'd0, d); check("R10 master bit cleared", d, 8'h01);
    check("R10 no select driven", ss_n_o, 1'b1);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
    reg_write(2'd0, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_master(8'hA5, 8'h3C, 1'b0, 3'b000);
    t_master(8'h4E, 8'hC1, 1'b1, 3'b001);
    t_master(8'h69, 8'hD2, 1'b0, 3'b100);
    t_rate(3'b100, 2);
    t_rate(3'b000, 4);
    t_rate(3'b101, 8);
    t_rate(3'b111, 64);
    t_rate(3'b011, 128);
    t_collision();
    t_clear_order();
    t_slave(8'hC3, 8'h5A, 1'b0);
    t_slave(8'h17, 8'hB4, 1'b1);
    t_ss_abort();
    t_mode_fault();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule